// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Accumulator

This unit sits beside a 32-bit integer pipeline and carries out the long-latency arithmetic that the pipeline does not do itself. The pipeline issues an operation code and two 32-bit operands. The unit runs the operation over several cycles and writes a 64-bit result into a pair of 32-bit result registers, HI and LO. It can multiply signed or unsigned values into a 64-bit product. It can add a product to the current HI/LO contents. It can divide signed or unsigned values, which leaves the quotient in LO and the remainder in HI.

A multiply or multiply-accumulate always takes five cycles. An unsigned divide takes 34 cycles. A signed divide takes 35, because one extra cycle fixes the signs. While the unit works, it holds `busy`. A requester that wants HI/LO during that time sees `stall` and must wait. Accumulation can run in a saturating mode, set through a small control write, in which it clamps instead of wrapping. An overflowing accumulate sets a sticky flag, and the same control write clears it.

Top module: `mdu_unit`

## Requirements
- R1: After reset, HI, LO, `busy`, `done`, `stall`, `ovf` and `sat_mode` are all zero.
- R2: Operation codes are 0 = signed multiply and 1 = unsigned multiply. Either one writes the full 64-bit product with its upper half in HI and its lower half in LO.
- R3: A multiply or multiply-accumulate accepted at clock edge E0 writes HI/LO at edge E0+5. `busy` is high from E0 to E0+5. `done` is high for the cycle after E0+5.
- R4: Operation codes are 2 = signed accumulate and 3 = unsigned accumulate. With saturation off, either one writes {HI,LO} + product, wrapped modulo 2^64.
- R5: An accumulate whose exact sum does not fit 64 bits sets `ovf`. For a signed accumulate that means outside the signed range; for an unsigned one it means above 2^64-1. `ovf` stays set through later operations. A control write (`ctl_we`) with `ctl_ovf_clr` set clears it.
- R6: A control write loads `sat_mode` from `ctl_sat`. With `sat_mode` set, an overflowing signed accumulate leaves 0x7FFFFFFFFFFFFFFF or 0x8000000000000000, following the sign of the true sum. An overflowing unsigned accumulate leaves all ones.
- R7: Operation code 5 (unsigned divide) writes the quotient to LO and the remainder to HI at edge E0+34.
- R8: Operation code 4 (signed divide) truncates the quotient toward zero. The remainder takes the sign of the dividend. Both are written at edge E0+35. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R9: A divide by zero takes the normal cycle count and raises no error. HI receives the dividend. LO receives 0xFFFFFFFF, except for a signed divide of a negative dividend, where LO receives 1.
- R10: `stall` is high exactly when `rd_req` is high while `busy` is high. HI and LO keep their values while an operation is in progress.
- R11: An issue while `busy` is high is ignored. An issue with code 6 or 7 is ignored. In both cases `busy` stays as it was and HI/LO do not change.
- R12: `done` never stays high for two cycles in a row, and each accepted operation yields exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue strobe |
| iss_op | input | 3 | Operation code (see R2, R4, R7, R8) |
| iss_a | input | 32 | First operand, dividend for divides |
| iss_b | input | 32 | Second operand, divisor for divides |
| rd_req | input | 1 | Requester wants to read HI/LO |
| ctl_we | input | 1 | Control write strobe |
| ctl_sat | input | 1 | New saturation mode on a control write |
| ctl_ovf_clr | input | 1 | Clear overflow flag on a control write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Read of HI/LO must wait |
| hi | output | 32 | HI result register |
| lo | output | 32 | LO result register |
| sat_mode | output | 1 | Current saturation mode |
| ovf | output | 1 | Sticky accumulate overflow flag |

## Verification
The bench keeps its own model of HI/LO, of the overflow flag and of the saturation mode, and it checks both the values and the exact number of cycles each operation takes.

Accumulates are driven past both signed limits and past the unsigned limit, with saturation off and with it on. A design that compared signs wrongly would wrap where it should clamp, or clamp to the wrong end of the range.

The signed divides cover every sign combination, the most negative value divided by -1, and division by zero. A design with a wrong sign-fix cycle would get the remainder sign wrong or finish one cycle off.

Issues made while the unit is busy, and reserved opcodes, are driven to show they are dropped. If either were accepted, a second `done` pulse or a changed HI/LO would appear.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned DLEN      = 2 * XLEN;
  localparam int unsigned MUL_DIGIT = 8;
  localparam int unsigned MUL_STEPS = XLEN / MUL_DIGIT;
  localparam int unsigned DSEL_W    = $clog2(MUL_STEPS);
  localparam int unsigned MUL_LAT   = MUL_STEPS + 1;
  localparam int unsigned DIVU_LAT  = XLEN + 2;
  localparam int unsigned DIVS_LAT  = XLEN + 3;
  localparam int unsigned STEP_W    = $clog2(DIVS_LAT + 1);

  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_MAC_S = 3'd2,
    OP_MAC_U = 3'd3,
    OP_DIV_S = 3'd4,
    OP_DIV_U = 3'd5
  } mdu_op_e;

  typedef struct packed {
    logic [DLEN-1:0] val;
    logic            ovf;
  } acc_res_t;

  function automatic logic op_known(logic [2:0] op);
    return op <= OP_DIV_U;
  endfunction

  function automatic logic op_is_mul(logic [2:0] op);
    return (op == OP_MUL_S) || (op == OP_MUL_U) || (op == OP_MAC_S) || (op == OP_MAC_U);
  endfunction

  function automatic logic op_is_mac(logic [2:0] op);
    return (op == OP_MAC_S) || (op == OP_MAC_U);
  endfunction

  function automatic logic op_is_div(logic [2:0] op);
    return (op == OP_DIV_S) || (op == OP_DIV_U);
  endfunction

  function automatic logic op_signed(logic [2:0] op);
    return (op == OP_MUL_S) || (op == OP_MAC_S) || (op == OP_DIV_S);
  endfunction

  function automatic int unsigned op_latency(logic [2:0] op);
    if (op == OP_DIV_U) return DIVU_LAT;
    if (op == OP_DIV_S) return DIVS_LAT;
    return MUL_LAT;
  endfunction

  // magnitude of a word, treating it as two's complement only when sgn is set
  function automatic logic [XLEN-1:0] magnitude(logic [XLEN-1:0] v, logic sgn);
    return (sgn && v[XLEN-1]) ? (~v + 1'b1) : v;
  endfunction

  // 65-bit exact sum; overflow when the exact sum leaves the 64-bit range
  function automatic acc_res_t accumulate(logic [DLEN-1:0] acc, logic [DLEN-1:0] prod,
                                          logic sgn, logic sat);
    acc_res_t        r;
    logic [DLEN:0]   sum;
    logic [DLEN-1:0] clamp;
    if (sgn) begin
      sum   = {acc[DLEN-1], acc} + {prod[DLEN-1], prod};
      r.ovf = sum[DLEN] ^ sum[DLEN-1];
      clamp = sum[DLEN] ? {1'b1, {(DLEN-1){1'b0}}} : {1'b0, {(DLEN-1){1'b1}}};
    end else begin
      sum   = {1'b0, acc} + {1'b0, prod};
      r.ovf = sum[DLEN];
      clamp = {DLEN{1'b1}};
    end
    r.val = (r.ovf && sat) ? clamp : sum[DLEN-1:0];
    return r;
  endfunction
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [2:0]        iss_op,
  output logic              busy,
  output logic              done,
  output logic              start,
  output logic              finish,
  output logic [STEP_W-1:0] step,
  output logic [2:0]        cur_op
);
  logic [STEP_W-1:0] last_step;

  assign start     = iss_valid && !busy && op_known(iss_op);
  assign last_step = STEP_W'(op_latency(cur_op) - 1);
  assign finish    = busy && (step == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      cur_op <= 3'd0;
    end else begin
      done <= finish;
      if (start) begin
        busy   <= 1'b1;
        step   <= '0;
        cur_op <= iss_op;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

  // independent cycle counter for latency checks
  logic [STEP_W-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_cnt <= '0;
    else if (start)  chk_cnt <= '0;
    else if (busy)   chk_cnt <= chk_cnt + 1'b1;
  end

  assert_mul_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_is_mul(cur_op) |-> chk_cnt == STEP_W'(MUL_LAT));
  assert_divu_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cur_op == OP_DIV_U) |-> chk_cnt == STEP_W'(DIVU_LAT));
  assert_divs_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cur_op == OP_DIV_S) |-> chk_cnt == STEP_W'(DIVS_LAT));
  assert_issue_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> busy && $stable(cur_op));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        iss_op,
  input  logic [XLEN-1:0]   iss_a,
  input  logic [XLEN-1:0]   iss_b,
  input  logic              busy,
  input  logic [2:0]        cur_op,
  input  logic [STEP_W-1:0] step,
  output logic [DLEN-1:0]   prod
);
  logic [XLEN-1:0]      ma, mb;
  logic [DLEN-1:0]      part;
  logic                 neg;
  logic                 active;
  logic [MUL_DIGIT-1:0] digits [MUL_STEPS];
  logic [DLEN-1:0]      pp;

  for (genvar g = 0; g < MUL_STEPS; g++) begin : g_digit
    assign digits[g] = mb[g*MUL_DIGIT +: MUL_DIGIT];
  end

  assign active = busy && op_is_mul(cur_op) && (step < STEP_W'(MUL_STEPS));
  assign pp     = (DLEN'(ma) * DLEN'(digits[step[DSEL_W-1:0]])) << (MUL_DIGIT * step[DSEL_W-1:0]);
  assign prod   = neg ? (~part + 1'b1) : part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma   <= '0;
      mb   <= '0;
      neg  <= 1'b0;
      part <= '0;
    end else if (start) begin
      ma   <= magnitude(iss_a, op_signed(iss_op));
      mb   <= magnitude(iss_b, op_signed(iss_op));
      neg  <= op_signed(iss_op) && (iss_a[XLEN-1] ^ iss_b[XLEN-1]);
      part <= '0;
    end else if (active) begin
      part <= part + pp;
    end
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        iss_op,
  input  logic [XLEN-1:0]   iss_a,
  input  logic [XLEN-1:0]   iss_b,
  input  logic              busy,
  input  logic [2:0]        cur_op,
  input  logic [STEP_W-1:0] step,
  output logic [XLEN-1:0]   quo,
  output logic [XLEN-1:0]   rem
);
  logic [XLEN-1:0] ra, rb, dvs;
  logic            sgn, neg_q, neg_r;
  logic            active;
  logic [XLEN:0]   sh;
  logic            ge;

  assign active = busy && op_is_div(cur_op);
  assign sh     = {rem, quo[XLEN-1]};
  assign ge     = sh >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra <= '0; rb <= '0; dvs <= '0; quo <= '0; rem <= '0;
      sgn <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0;
    end else if (start) begin
      ra  <= iss_a;
      rb  <= iss_b;
      sgn <= op_signed(iss_op);
    end else if (active) begin
      if (step == '0) begin
        quo   <= magnitude(ra, sgn);
        dvs   <= magnitude(rb, sgn);
        rem   <= '0;
        neg_q <= sgn && (ra[XLEN-1] ^ rb[XLEN-1]);
        neg_r <= sgn && ra[XLEN-1];
      end else if (step <= STEP_W'(XLEN)) begin
        rem <= ge ? XLEN'(sh - {1'b0, dvs}) : sh[XLEN-1:0];
        quo <= {quo[XLEN-2:0], ge};
      end else if (step == STEP_W'(XLEN + 1)) begin
        quo <= neg_q ? (~quo + 1'b1) : quo;
        rem <= neg_r ? (~rem + 1'b1) : rem;
      end
    end
  end

  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && (step >= STEP_W'(1)) && (step <= STEP_W'(XLEN + 1)) |-> (dvs == '0) || (rem < dvs));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [2:0]      iss_op,
  input  logic [XLEN-1:0] iss_a,
  input  logic [XLEN-1:0] iss_b,
  input  logic            rd_req,
  input  logic            ctl_we,
  input  logic            ctl_sat,
  input  logic            ctl_ovf_clr,
  output logic            busy,
  output logic            done,
  output logic            stall,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo,
  output logic            sat_mode,
  output logic            ovf
);
  logic              start, finish;
  logic [STEP_W-1:0] step;
  logic [2:0]        cur_op;
  logic [DLEN-1:0]   prod;
  logic [XLEN-1:0]   quo, rem;
  logic [XLEN-1:0]   hi_q, lo_q;
  logic              sat_q, ovf_q;
  acc_res_t          acc;
  logic              acc_ovf_evt;
  logic              wr_hilo;

  mdu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .busy(busy), .done(done), .start(start), .finish(finish),
    .step(step), .cur_op(cur_op)
  );

  mdu_mul u_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .busy(busy), .cur_op(cur_op),
    .step(step), .prod(prod)
  );

  mdu_div u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .busy(busy), .cur_op(cur_op),
    .step(step), .quo(quo), .rem(rem)
  );

  assign acc         = accumulate({hi_q, lo_q}, prod, op_signed(cur_op), sat_q);
  assign wr_hilo     = finish;
  assign acc_ovf_evt = finish && op_is_mac(cur_op) && acc.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_hilo) begin
      if (op_is_div(cur_op))      {hi_q, lo_q} <= {rem, quo};
      else if (op_is_mac(cur_op)) {hi_q, lo_q} <= acc.val;
      else                        {hi_q, lo_q} <= prod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (ctl_we) sat_q <= ctl_sat;
      if (acc_ovf_evt)                  ovf_q <= 1'b1;
      else if (ctl_we && ctl_ovf_clr)   ovf_q <= 1'b0;
    end
  end

  assign stall    = rd_req && busy;
  assign hi       = hi_q;
  assign lo       = lo_q;
  assign sat_mode = sat_q;
  assign ovf      = ovf_q;

  assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable({hi_q, lo_q}));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(ctl_we && ctl_ovf_clr) |=> ovf_q);
  assert_sat_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ovf_evt && sat_q |=> ({hi_q, lo_q} == {1'b0, {(DLEN-1){1'b1}}}) ||
                             ({hi_q, lo_q} == {1'b1, {(DLEN-1){1'b0}}}) ||
                             ({hi_q, lo_q} == {DLEN{1'b1}}));
  assert_ovf_needs_mac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> done && op_is_mac(cur_op));
endmodule

// File: tb/mdu_unit_tb.sv
module mdu_unit_tb;
  localparam logic [2:0] MS = 3'd0, MU = 3'd1, AS = 3'd2, AU = 3'd3, DS = 3'd4, DU = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_op = 3'd0;
  logic [31:0] iss_a = '0, iss_b = '0;
  logic        rd_req = 1'b0, ctl_we = 1'b0, ctl_sat = 1'b0, ctl_ovf_clr = 1'b0;
  logic        busy, done, stall, sat_mode, ovf;
  logic [31:0] hi, lo;

  always #10 clk = ~clk;

  mdu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .rd_req(rd_req), .ctl_we(ctl_we),
    .ctl_sat(ctl_sat), .ctl_ovf_clr(ctl_ovf_clr), .busy(busy), .done(done),
    .stall(stall), .hi(hi), .lo(lo), .sat_mode(sat_mode), .ovf(ovf)
  );

  typedef struct {
    logic [63:0] hl;
    bit          ov;
    longint      iss_cyc;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  longint      cyc = 0;
  logic [63:0] m_hl = '0;
  bit          m_ovf = 1'b0, m_sat = 1'b0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({hi, lo} == e.hl, {e.tag, " value"}, {hi, lo}, e.hl);
        check(ovf == e.ov, {e.tag, " ovf R5"}, 64'(ovf), 64'(e.ov));
        check(cyc - e.iss_cyc == longint'(e.lat), {e.tag, " latency"}, 64'(cyc - e.iss_cyc), 64'(e.lat));
      end
    end
    if (cyc > 100000) begin
      check(1'b0, "watchdog", 64'(cyc), 64'd100000);
      finish_run();
    end
  end

  function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                output int lat);
    logic [63:0] p, s;
    logic [31:0] q, r;
    longint      sa, sb_;
    bit          ov;
    sa  = $signed(a);
    sb_ = $signed(b);
    lat = 5;
    case (op)
      MS: m_hl = 64'(sa * sb_);
      MU: m_hl = {32'd0, a} * {32'd0, b};
      AS: begin
        p  = 64'(sa * sb_);
        s  = m_hl + p;
        ov = (m_hl[63] == p[63]) && (s[63] != m_hl[63]);
        if (ov) begin
          m_ovf = 1'b1;
          if (m_sat) s = m_hl[63] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
        end
        m_hl = s;
      end
      AU: begin
        p  = {32'd0, a} * {32'd0, b};
        s  = m_hl + p;
        ov = s < m_hl;
        if (ov) begin
          m_ovf = 1'b1;
          if (m_sat) s = '1;
        end
        m_hl = s;
      end
      DS: begin
        lat = 35;
        if (b == 0) begin
          q = a[31] ? 32'd1 : 32'hFFFF_FFFF;
          r = a;
        end else begin
          q = 32'(sa / sb_);
          r = 32'(sa % sb_);
        end
        m_hl = {r, q};
      end
      default: begin
        lat = 34;
        if (b == 0) begin
          q = 32'hFFFF_FFFF;
          r = a;
        end else begin
          q = a / b;
          r = a % b;
        end
        m_hl = {r, q};
      end
    endcase
  endfunction

  // driver: pushes the expected item, issues, waits for completion
  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                     input string tag, input bit probe);
    exp_t        e;
    int          lat;
    logic [63:0] old_hl;
    old_hl = m_hl;
    model(op, a, b, lat);
    @(negedge clk);
    e.hl = m_hl; e.ov = m_ovf; e.iss_cyc = cyc + 1; e.lat = lat; e.tag = tag;
    sb.push_back(e);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b;
    @(negedge clk);
    iss_valid = 1'b0;
    if (probe) begin
      rd_req = 1'b1;
      @(negedge clk);
      check(stall == 1'b1, "R10 stall while busy", 64'(stall), 64'd1);
      check({hi, lo} == old_hl, "R10 hilo held while busy", {hi, lo}, old_hl);
    end
    while (busy) @(negedge clk);
    if (probe) begin
      check(stall == 1'b0, "R10 no stall when idle", 64'(stall), 64'd0);
      rd_req = 1'b0;
    end
  endtask

  task automatic ctl(input bit sat, input bit clr);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sat = sat; ctl_ovf_clr = clr;
    @(negedge clk);
    ctl_we = 1'b0; ctl_ovf_clr = 1'b0;
    m_sat = sat;
    if (clr) m_ovf = 1'b0;
    check(sat_mode == sat, "R6 sat_mode write", 64'(sat_mode), 64'(sat));
    check(ovf == m_ovf, "R5 ovf after control write", 64'(ovf), 64'(m_ovf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({hi, lo} == 64'd0, "R1 hilo reset", {hi, lo}, 64'd0);
    check({busy, done, stall, ovf, sat_mode} == 5'd0, "R1 status reset",
          64'({busy, done, stall, ovf, sat_mode}), 64'd0);

    // R2/R3 multiplies
    run(MS, 32'd7, 32'hFFFF_FFFD, "R2 R3 mul signed 7*-3", 1'b0);
    run(MS, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mul signed -1*-1", 1'b0);
    run(MS, 32'h8000_0000, 32'h8000_0000, "R2 mul signed min*min", 1'b0);
    run(MU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mul unsigned max*max", 1'b0);
    run(MU, 32'h1234_5678, 32'h9ABC_DEF0, "R2 mul unsigned mixed", 1'b0);

    // R4/R5 wrapping accumulate and sticky flag
    run(MS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 seed", 1'b0);
    run(AS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 mac signed no ovf", 1'b0);
    run(AS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 R5 mac signed wrap", 1'b0);
    run(MU, 32'd3, 32'd5, "R5 flag stays after mul", 1'b0);
    run(AU, 32'd1, 32'd1, "R4 mac unsigned small", 1'b0);
    ctl(1'b0, 1'b1);

    // R6 saturation, both signed ends and unsigned
    ctl(1'b1, 1'b0);
    run(MS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R6 seed pos", 1'b0);
    run(AS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R6 mac pos", 1'b0);
    run(AS, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R6 clamp max", 1'b0);
    run(AS, 32'd1, 32'd1, "R6 stay max", 1'b0);
    ctl(1'b1, 1'b1);
    run(MS, 32'h8000_0000, 32'h7FFF_FFFF, "R6 seed neg", 1'b0);
    run(AS, 32'h8000_0000, 32'h7FFF_FFFF, "R6 mac neg", 1'b0);
    run(AS, 32'h8000_0000, 32'h7FFF_FFFF, "R6 clamp min", 1'b0);
    ctl(1'b1, 1'b1);
    run(MU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 seed unsigned", 1'b0);
    run(AU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 mac unsigned", 1'b0);
    run(AU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 clamp unsigned", 1'b0);
    ctl(1'b0, 1'b1);

    // R7 unsigned divide, with R10 stall probe
    run(DU, 32'd100, 32'd7, "R7 R10 divu 100/7", 1'b1);
    run(DU, 32'hFFFF_FFFF, 32'd1, "R7 divu max/1", 1'b0);
    run(DU, 32'd5, 32'd10, "R7 divu 5/10", 1'b0);
    run(DU, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R7 divu near max", 1'b0);

    // R8 signed divide
    run(DS, 32'hFFFF_FFF9, 32'd2, "R8 div -7/2", 1'b1);
    run(DS, 32'd7, 32'hFFFF_FFFE, "R8 div 7/-2", 1'b0);
    run(DS, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R8 div -7/-2", 1'b0);
    run(DS, 32'h8000_0000, 32'hFFFF_FFFF, "R8 div min/-1", 1'b0);

    // R9 divide by zero
    run(DU, 32'd1234, 32'd0, "R9 divu by zero", 1'b0);
    run(DS, 32'hFFFF_FFFB, 32'd0, "R9 div neg by zero", 1'b0);
    run(DS, 32'd9, 32'd0, "R9 div pos by zero", 1'b0);

    // R11 issue while busy is dropped
    begin
      exp_t e;
      int   lat;
      model(MU, 32'd6, 32'd7, lat);
      @(negedge clk);
      e.hl = m_hl; e.ov = m_ovf; e.iss_cyc = cyc + 1; e.lat = lat; e.tag = "R11 first op kept";
      sb.push_back(e);
      iss_valid = 1'b1; iss_op = MU; iss_a = 32'd6; iss_b = 32'd7;
      @(negedge clk);
      iss_op = DS; iss_a = 32'd50; iss_b = 32'd3;
      repeat (2) @(negedge clk);
      iss_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R11 busy issue ignored", 64'(busy), 64'd0);
      check({hi, lo} == m_hl, "R11 hilo after ignored issue", {hi, lo}, m_hl);
    end

    // R11 reserved opcodes
    for (int k = 6; k < 8; k++) begin
      @(negedge clk);
      iss_valid = 1'b1; iss_op = 3'(k); iss_a = 32'd11; iss_b = 32'd2;
      @(negedge clk);
      iss_valid = 1'b0;
      check(busy == 1'b0, "R11 reserved opcode not accepted", 64'(busy), 64'd0);
      repeat (6) @(negedge clk);
      check({hi, lo} == m_hl, "R11 reserved opcode hilo", {hi, lo}, m_hl);
    end

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R12 every op completed once", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule